// File: doc/BRIEF.md
# Regulator Channel Fault Protection Sequencer

This block sits beside the regulator channels of a satellite dish supply and decides, cycle by cycle, whether each channel's output stage may conduct. It takes digitized comparator results for each channel (overload and reverse "back" current), a chip-wide over-temperature pair (a hot trip and a cooled-down release), a per-channel mode bit and per-channel enables. It produces registered output-enable lines, status flags and an active-low interrupt for the host processor.

Each channel has two independent timed machines. The overload machine works in one of two modes. In timed-retry mode it turns the channel off for a long rest window when an overload persists, then tries a short on window, and repeats until the overload is gone. In follow mode the overload flag simply tracks the comparator. The back-current machine runs its own detect/off cycle with different windows. Every window counts a clock-enable tick, so the real microsecond and millisecond values are parameters and a testbench can shrink them.

Top module: `lnb_fault_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_en`, `ovl_flag`, `bc_flag` and `ot_flag` are all zero and `fault_n` is 0 (all enables are zero at reset).
- R2: With no faults, `out_en[i]` equals `ch_en[i]` one cycle later.
- R3: In timed-retry mode (`static_mode[i]`=0) an overload held for OL_DET_TICKS ticks after it is first seen sets `ovl_flag[i]` and, one cycle after that, drops `out_en[i]`.
- R4: After the trip the channel stays off for OL_OFF_TICKS ticks, then on for OL_ON_TICKS ticks; if the overload is present at the end of the on window, the off/on cycle repeats with the flag held.
- R5: If the overload is absent at the end of the on window, `ovl_flag[i]` clears and the channel returns to normal; an overload that drops before the detect window ends leaves no flag and no shutdown.
- R6: In follow mode (`static_mode[i]`=1) `ovl_flag[i]` equals `ovl_in[i]` one cycle later and the overload never turns the output off.
- R7: A change of `static_mode[i]` aborts any overload cycle in progress: on the next edge the machine is idle with its flag clear and its hold released.
- R8: A back-current input held for BC_DET_TICKS ticks sets `bc_flag[i]` and turns the channel off for BC_OFF_TICKS ticks; the channel is then on again for a new detect window, and the cycle repeats while the input stays high.
- R9: When `bc_in[i]` is low while the back-current machine is in an on/detect window, `bc_flag[i]` clears on that edge.
- R10: `hot_in` sets `ot_flag`, which turns all outputs off one cycle later; `ot_flag` clears only on an edge with `cool_in` high and `hot_in` low.
- R11: `fault_n` is the registered inverse of: `ot_flag`, any `ovl_flag` or `bc_flag`, or all `ch_en` bits low.
- R12: While `ch_en[i]` is low or `ot_flag` is high, both machines of channel i are held idle with their flags clear.
- R13: Windows advance only on cycles where `tick` is high; cycles without a tick do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base clock enable for all windows |
| ch_en | input | NUM_CH | Per-channel output enable request |
| static_mode | input | NUM_CH | 1 = follow mode, 0 = timed-retry overload mode |
| ovl_in | input | NUM_CH | Overload comparator, per channel |
| bc_in | input | NUM_CH | Back-current comparator, per channel |
| hot_in | input | 1 | Over-temperature trip |
| cool_in | input | 1 | Cooled below release threshold |
| out_en | output | NUM_CH | Registered output-stage enable |
| ovl_flag | output | NUM_CH | Overload status |
| bc_flag | output | NUM_CH | Back-current status |
| ot_flag | output | 1 | Over-temperature status |
| fault_n | output | 1 | Active-low interrupt |

## Verification
The hardest situation to reach is a mode change in the middle of a timed overload rest window, because it requires a trip to have completed first and the bit to flip while the output is still held off. The bench holds an overload long enough to trip the channel, flips the mode bit inside the rest window and compares every cycle against a behavioural model. A sparse tick pattern is also used so that windows spanning cycles without a tick are exercised.

// File: rtl/lnb_fault_pkg.sv
package lnb_fault_pkg;

  typedef enum logic [1:0] {
    OL_IDLE = 2'd0,
    OL_DET  = 2'd1,
    OL_OFF  = 2'd2,
    OL_ON   = 2'd3
  } ol_state_e;

  typedef enum logic [1:0] {
    BC_IDLE = 2'd0,
    BC_DET  = 2'd1,
    BC_OFF  = 2'd2
  } bc_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lnb_ovl_guard.sv
module lnb_ovl_guard
  import lnb_fault_pkg::*;
#(
  parameter int DET_TICKS = 23,
  parameter int OFF_TICKS = 900000,
  parameter int ON_TICKS  = 20000,
  parameter int CNT_W     = 21
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic static_mode,
  input  logic ovl_in,
  output logic hold_off,
  output logic flag
);

  ol_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic             mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= OL_IDLE;
      cnt    <= '0;
      flag   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= static_mode;
      if (!run || (static_mode != mode_q)) begin
        st   <= OL_IDLE;
        cnt  <= '0;
        flag <= 1'b0;
      end else if (static_mode) begin
        st   <= OL_IDLE;
        cnt  <= '0;
        flag <= ovl_in;
      end else begin
        unique case (st)
          OL_IDLE: begin
            flag <= 1'b0;
            if (ovl_in) begin
              st  <= OL_DET;
              cnt <= '0;
            end
          end
          OL_DET: begin
            if (!ovl_in) begin
              st <= OL_IDLE;
            end else if (tick) begin
              if (cnt == CNT_W'(DET_TICKS - 1)) begin
                st   <= OL_OFF;
                cnt  <= '0;
                flag <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          OL_OFF: begin
            if (tick) begin
              if (cnt == CNT_W'(OFF_TICKS - 1)) begin
                st  <= OL_ON;
                cnt <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          OL_ON: begin
            if (tick) begin
              if (cnt == CNT_W'(ON_TICKS - 1)) begin
                cnt <= '0;
                if (ovl_in) begin
                  st <= OL_OFF;
                end else begin
                  st   <= OL_IDLE;
                  flag <= 1'b0;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: st <= OL_IDLE;
        endcase
      end
    end
  end

  assign hold_off = (st == OL_OFF);

endmodule

// File: rtl/lnb_bc_guard.sv
module lnb_bc_guard
  import lnb_fault_pkg::*;
#(
  parameter int DET_TICKS = 100,
  parameter int OFF_TICKS = 5000,
  parameter int CNT_W     = 21
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic bc_in,
  output logic hold_off,
  output logic flag
);

  bc_state_e        st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      st   <= BC_IDLE;
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      unique case (st)
        BC_IDLE: begin
          flag <= 1'b0;
          if (bc_in) begin
            st  <= BC_DET;
            cnt <= '0;
          end
        end
        BC_DET: begin
          if (!bc_in) begin
            st   <= BC_IDLE;
            flag <= 1'b0;
          end else if (tick) begin
            if (cnt == CNT_W'(DET_TICKS - 1)) begin
              st   <= BC_OFF;
              cnt  <= '0;
              flag <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        BC_OFF: begin
          if (tick) begin
            if (cnt == CNT_W'(OFF_TICKS - 1)) begin
              st  <= BC_DET;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= BC_IDLE;
      endcase
    end
  end

  assign hold_off = (st == BC_OFF);

endmodule

// File: rtl/lnb_therm_latch.sv
module lnb_therm_latch (
  input  logic clk,
  input  logic rst,
  input  logic hot_in,
  input  logic cool_in,
  output logic hot_q
);

  always_ff @(posedge clk) begin
    if (rst)          hot_q <= 1'b0;
    else if (hot_in)  hot_q <= 1'b1;
    else if (cool_in) hot_q <= 1'b0;
  end

endmodule

// File: rtl/lnb_fault_seq.sv
module lnb_fault_seq
  import lnb_fault_pkg::*;
#(
  parameter int NUM_CH       = 2,
  parameter int OL_DET_TICKS = 23,
  parameter int OL_OFF_TICKS = 900000,
  parameter int OL_ON_TICKS  = 20000,
  parameter int BC_DET_TICKS = 100,
  parameter int BC_OFF_TICKS = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] static_mode,
  input  logic [NUM_CH-1:0] ovl_in,
  input  logic [NUM_CH-1:0] bc_in,
  input  logic              hot_in,
  input  logic              cool_in,
  output logic [NUM_CH-1:0] out_en,
  output logic [NUM_CH-1:0] ovl_flag,
  output logic [NUM_CH-1:0] bc_flag,
  output logic              ot_flag,
  output logic              fault_n
);

  localparam int MAX_TICKS = max_int(max_int(max_int(OL_DET_TICKS, OL_OFF_TICKS),
                                             max_int(OL_ON_TICKS, BC_DET_TICKS)),
                                     BC_OFF_TICKS);
  localparam int CNT_W = $clog2(MAX_TICKS) + 1;

  logic [NUM_CH-1:0] ol_hold;
  logic [NUM_CH-1:0] bc_hold;
  logic [NUM_CH-1:0] run;
  logic              hot_q;

  lnb_therm_latch u_therm (
    .clk     (clk),
    .rst     (rst),
    .hot_in  (hot_in),
    .cool_in (cool_in),
    .hot_q   (hot_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign run[i] = ch_en[i] & ~hot_q;

    lnb_ovl_guard #(
      .DET_TICKS (OL_DET_TICKS),
      .OFF_TICKS (OL_OFF_TICKS),
      .ON_TICKS  (OL_ON_TICKS),
      .CNT_W     (CNT_W)
    ) u_ovl (
      .clk         (clk),
      .rst         (rst),
      .tick        (tick),
      .run         (run[i]),
      .static_mode (static_mode[i]),
      .ovl_in      (ovl_in[i]),
      .hold_off    (ol_hold[i]),
      .flag        (ovl_flag[i])
    );

    lnb_bc_guard #(
      .DET_TICKS (BC_DET_TICKS),
      .OFF_TICKS (BC_OFF_TICKS),
      .CNT_W     (CNT_W)
    ) u_bc (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .run      (run[i]),
      .bc_in    (bc_in[i]),
      .hold_off (bc_hold[i]),
      .flag     (bc_flag[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_en  <= '0;
      fault_n <= 1'b0;
    end else begin
      out_en  <= run & ~ol_hold & ~bc_hold;
      fault_n <= ~(hot_q | (|ovl_flag) | (|bc_flag) | ~(|ch_en));
    end
  end

  assign ot_flag = hot_q;

endmodule

// File: rtl/lnb_fault_seq_chk.sv
module lnb_fault_seq_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] static_mode,
  input logic [NUM_CH-1:0] ovl_in,
  input logic [NUM_CH-1:0] bc_in,
  input logic              hot_in,
  input logic              cool_in,
  input logic [NUM_CH-1:0] out_en,
  input logic [NUM_CH-1:0] ovl_flag,
  input logic [NUM_CH-1:0] bc_flag,
  input logic              ot_flag,
  input logic              fault_n
);

  assert_hot_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    ot_flag |=> (out_en == '0));

  assert_hot_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ot_flag) |-> $past(hot_in));

  assert_hot_release_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(ot_flag) |-> $past(cool_in) && !$past(hot_in));

  assert_all_off_irq_R11: assert property (@(posedge clk) disable iff (rst)
    (ch_en == '0) |=> !fault_n);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_out_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
      out_en[i] |-> $past(ch_en[i]));

    assert_bc_cause_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(bc_flag[i]) |-> $past(bc_in[i]));

    assert_idle_when_off_R12: assert property (@(posedge clk) disable iff (rst)
      !ch_en[i] |=> !ovl_flag[i] && !bc_flag[i]);

    assert_follow_mode_R6: assert property (@(posedge clk) disable iff (rst)
      static_mode[i] && $past(static_mode[i]) && ch_en[i] && !ot_flag
      |=> ovl_flag[i] == $past(ovl_in[i]));
  end

  wire unused_ok = tick ^ hot_in ^ cool_in;

endmodule

bind lnb_fault_seq lnb_fault_seq_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/lnb_fault_seq_tb.sv
`timescale 1ns/1ps
module lnb_fault_seq_tb;

  localparam int NC = 2;
  localparam int ODET = 4, OOFF = 10, OON = 3, BDET = 5, BOFF = 8;

  logic clk = 0;
  logic rst = 1;
  logic tick = 1;
  logic [NC-1:0] ch_en = '0, static_mode = '0, ovl_in = '0, bc_in = '0;
  logic hot_in = 0, cool_in = 0;
  logic [NC-1:0] out_en, ovl_flag, bc_flag;
  logic ot_flag, fault_n;

  always #10 clk = ~clk;

  lnb_fault_seq #(
    .NUM_CH(NC), .OL_DET_TICKS(ODET), .OL_OFF_TICKS(OOFF), .OL_ON_TICKS(OON),
    .BC_DET_TICKS(BDET), .BC_OFF_TICKS(BOFF)
  ) u_dut (.*);

  int n_checks = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;
  int sparse = 0, tick_div = 0;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // behavioural reference: 0 idle, 1 detect, 2 off, 3 on
  int  m_ol[NC], m_olc[NC], m_bc[NC], m_bcc[NC];
  bit  m_olf[NC], m_bcf[NC], m_mp[NC], m_ot;
  bit  e_out[NC], e_fn;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int i = 0; i < NC; i++) begin
        m_ol[i] = 0; m_olc[i] = 0; m_bc[i] = 0; m_bcc[i] = 0;
        m_olf[i] = 0; m_bcf[i] = 0; m_mp[i] = 0; e_out[i] = 0;
      end
      m_ot = 0; e_fn = 0;
    end else begin
      bit anyf;
      anyf = 0;
      for (int i = 0; i < NC; i++) begin
        e_out[i] = ch_en[i] && !m_ot && m_ol[i] != 2 && m_bc[i] != 2;
        anyf |= m_olf[i] | m_bcf[i];
      end
      e_fn = !(m_ot || anyf || ch_en == 0);
      for (int i = 0; i < NC; i++) begin
        bit r;
        r = ch_en[i] && !m_ot;
        // overload machine
        if (!r || static_mode[i] != m_mp[i]) begin
          m_ol[i] = 0; m_olc[i] = 0; m_olf[i] = 0;
        end else if (static_mode[i]) begin
          m_ol[i] = 0; m_olc[i] = 0; m_olf[i] = ovl_in[i];
        end else begin
          case (m_ol[i])
            0: begin m_olf[i] = 0; if (ovl_in[i]) begin m_ol[i] = 1; m_olc[i] = 0; end end
            1: if (!ovl_in[i]) m_ol[i] = 0;
               else if (tick) begin
                 m_olc[i]++;
                 if (m_olc[i] == ODET) begin m_ol[i] = 2; m_olc[i] = 0; m_olf[i] = 1; end
               end
            2: if (tick) begin
                 m_olc[i]++;
                 if (m_olc[i] == OOFF) begin m_ol[i] = 3; m_olc[i] = 0; end
               end
            default: if (tick) begin
                 m_olc[i]++;
                 if (m_olc[i] == OON) begin
                   m_olc[i] = 0;
                   if (ovl_in[i]) m_ol[i] = 2; else begin m_ol[i] = 0; m_olf[i] = 0; end
                 end
               end
          endcase
        end
        m_mp[i] = static_mode[i];
        // back-current machine
        if (!r) begin
          m_bc[i] = 0; m_bcc[i] = 0; m_bcf[i] = 0;
        end else begin
          case (m_bc[i])
            0: begin m_bcf[i] = 0; if (bc_in[i]) begin m_bc[i] = 1; m_bcc[i] = 0; end end
            1: if (!bc_in[i]) begin m_bc[i] = 0; m_bcf[i] = 0; end
               else if (tick) begin
                 m_bcc[i]++;
                 if (m_bcc[i] == BDET) begin m_bc[i] = 2; m_bcc[i] = 0; m_bcf[i] = 1; end
               end
            default: if (tick) begin
                 m_bcc[i]++;
                 if (m_bcc[i] == BOFF) begin m_bc[i] = 1; m_bcc[i] = 0; end
               end
          endcase
        end
      end
      if (hot_in) m_ot = 1; else if (cool_in) m_ot = 0;
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      int ea, ef_o, ef_b;
      ea = 0; ef_o = 0; ef_b = 0;
      for (int i = 0; i < NC; i++) begin
        ea |= int'(e_out[i]) << i;
        ef_o |= int'(m_olf[i]) << i;
        ef_b |= int'(m_bcf[i]) << i;
      end
      check({cur_req, " out_en"}, out_en, ea);
      check({cur_req, " ovl_flag"}, ovl_flag, ef_o);
      check({cur_req, " bc_flag"}, bc_flag, ef_b);
      check({cur_req, " ot_flag"}, ot_flag, m_ot);
      check({cur_req, " fault_n"}, fault_n, e_fn);
    end
  end

  // tick pattern driven at negedge
  always @(negedge clk) begin
    tick_div = (tick_div + 1) % 3;
    tick <= sparse ? (tick_div == 0) : 1'b1;
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    wait_n(3);
    check("R1 out_en in reset", out_en, 0);
    check("R1 fault_n in reset", fault_n, 0);
    rst = 0;
    wait_n(1);
    check("R1 flags after reset", {ovl_flag, bc_flag, ot_flag}, 0);

    cur_req = "R2"; ch_en = 2'b11; wait_n(3);
    check("R2 out_en follows enable", out_en, 3);
    check("R11 fault_n idle high", fault_n, 1);

    cur_req = "R3"; ovl_in[0] = 1; wait_n(8);
    check("R3 tripped output off", out_en[0], 0);
    check("R3 overload flag set", ovl_flag[0], 1);
    check("R11 fault_n on overload", fault_n, 0);
    cur_req = "R4"; wait_n(40);
    check("R4 flag held while retrying", ovl_flag[0], 1);
    cur_req = "R5"; ovl_in[0] = 0; wait_n(30);
    check("R5 flag cleared after recovery", ovl_flag[0], 0);
    check("R5 output restored", out_en[0], 1);
    ovl_in[0] = 1; wait_n(2); ovl_in[0] = 0; wait_n(6);
    check("R5 short overload ignored", {ovl_flag[0], out_en[0]}, 1);

    cur_req = "R6"; static_mode[1] = 1; wait_n(2); ovl_in[1] = 1; wait_n(3);
    check("R6 flag follows input", ovl_flag[1], 1);
    wait_n(25);
    check("R6 no shutdown in follow mode", out_en[1], 1);
    ovl_in[1] = 0; wait_n(2);
    check("R6 flag follows release", ovl_flag[1], 0);

    cur_req = "R7"; static_mode[1] = 0; wait_n(2); ovl_in[1] = 1; wait_n(8);
    check("R7 precondition tripped", out_en[1], 0);
    static_mode[1] = 1; wait_n(3);
    check("R7 abort releases output", out_en[1], 1);
    ovl_in[1] = 0; static_mode[1] = 0; wait_n(5);

    cur_req = "R8"; bc_in[0] = 1; wait_n(9);
    check("R8 back-current trip off", out_en[0], 0);
    check("R8 back-current flag", bc_flag[0], 1);
    wait_n(40);
    cur_req = "R9"; bc_in[0] = 0; wait_n(20);
    check("R9 back-current cleared", {bc_flag[0], out_en[0]}, 1);

    cur_req = "R13"; sparse = 1; wait_n(3); ovl_in[0] = 1; wait_n(9);
    check("R13 sparse ticks still detecting", out_en[0], 1);
    wait_n(20);
    check("R13 trip after enough ticks", out_en[0], 0);
    ovl_in[0] = 0; wait_n(60); sparse = 0; wait_n(10);

    cur_req = "R10"; hot_in = 1; wait_n(1); hot_in = 0; wait_n(2);
    check("R10 over-temp flag", ot_flag, 1);
    check("R10 outputs off", out_en, 0);
    wait_n(6);
    check("R10 held without cool", ot_flag, 1);
    cool_in = 1; wait_n(1); cool_in = 0; wait_n(2);
    check("R10 released by cool", {ot_flag, out_en}, 3);

    cur_req = "R12"; ch_en = 2'b00; wait_n(3);
    check("R11 fault_n with all disabled", fault_n, 0);
    ovl_in[0] = 1; bc_in[1] = 1; wait_n(12);
    check("R12 disabled channel stays idle", {ovl_flag, bc_flag}, 0);
    ovl_in = 0; bc_in = 0; ch_en = 2'b01; wait_n(4);
    check("R12 single channel on", out_en, 1);

    finish_run();
  end

  initial begin
    #(20 * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

endmodule